// File: doc/BRIEF.md
# Double-Buffered Nine-Bit UART Transmitter

This block serialises bytes from a processor onto an asynchronous serial line. It supports a ten-bit frame: a low start bit, eight data bits with the least significant bit first, and a high stop bit. It also supports an eleven-bit frame that places a programmable ninth bit between the data and the stop bit. A small front end derives the baud tick, and one bit always lasts 16 ticks. In the fixed-rate mode the tick comes from the core clock. In the variable-rate modes it comes from either an external timer-overflow pulse or an internal divisor counter.

A one-entry holding buffer can be enabled. When it is on, software may load the next byte, together with its ninth bit, while the current frame is still shifting. The transmit flag then means "buffer free", and frames can follow one another with a single stop bit between them. When the buffer is off, the flag marks the end of a frame, and the ninth bit is read from its input at the moment it goes out on the line. A write that finds no room is dropped and sets a sticky overrun bit.

Top module: `uart9_tx`

## Requirements
- R1: After reset, `txd_o` is 1, `tx_irq_o` is 0 and `overrun_o` is 0. The line stays high whenever no frame is in progress.
- R2: With `mode_i` set to 0 or 1, a frame is 10 bits long: a 0, then `wr_data_i` bit 0 through bit 7, then a 1.
- R3: With `mode_i` set to 2 or 3, a frame is 11 bits long: a 0, then data bits 0 through 7, then the ninth bit, then a 1.
- R4: With `mode_i`=2, one bit lasts 16 core cycles when `rate_dbl_i`=1 and 32 core cycles when `rate_dbl_i`=0.
- R5: With `mode_i` set to 1 or 3 and `src_sel_i`=1, one bit lasts 16*(`div_i`+1) core cycles.
- R6: With `mode_i` set to 1 or 3 and `src_sel_i`=0, one bit lasts 16 `timer_tick_i` pulses when `rate_dbl_i`=1 and 32 pulses when `rate_dbl_i`=0.
- R7: With `dbuf_en_i`=1, `tx_irq_o` is set on the cycle the held byte moves into the shifter. It is not set when a frame ends.
- R8: With `dbuf_en_i`=1, the ninth bit sent is the value `bit9_i` had in the write cycle. Later changes to `bit9_i` have no effect on it.
- R9: With `dbuf_en_i`=1, a byte written during a frame starts its start bit directly after that frame's single stop bit.
- R10: With `dbuf_en_i`=0, `tx_irq_o` is set when the stop bit ends. The ninth bit is the value of `bit9_i` at the start of the ninth bit period.
- R11: A write that finds no room is discarded and sets `overrun_o`, which stays set until reset. There is no room when the buffer is off and a frame is in progress, or when the buffer is on and the holding slot is full.
- R12: A pulse on `irq_clr_i` clears `tx_irq_o` when no new set event occurs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_i | input | 1 | One-cycle write strobe |
| wr_data_i | input | 8 | Byte to send |
| bit9_i | input | 1 | Ninth-bit value |
| mode_i | input | 2 | Frame and rate mode (0/1 ten-bit, 2 fixed-rate eleven-bit, 3 variable-rate eleven-bit) |
| dbuf_en_i | input | 1 | Holding buffer enable |
| rate_dbl_i | input | 1 | Rate-doubling control |
| src_sel_i | input | 1 | Variable-rate source: 1 divisor counter, 0 timer pulse |
| timer_tick_i | input | 1 | Timer overflow pulse |
| div_i | input | 16 | Divisor counter reload value |
| irq_clr_i | input | 1 | Clears the transmit flag |
| txd_o | output | 1 | Serial line |
| tx_irq_o | output | 1 | Transmit flag |
| overrun_o | output | 1 | Sticky dropped-write status |

## Verification
The bench writes a second byte while the first frame is still shifting. If the handoff at the end of a frame were wrong, the second start bit would come late, or the frame would be dropped or sent with two stop bits. The bench changes `bit9_i` after each write. In buffered mode, a design that samples the ninth bit live would send the wrong value. In unbuffered mode, a design that latches the ninth bit early would send a stale value. It also checks the flag partway through frames: a buffered design that set the flag at frame end, or an unbuffered one that set it at load, shows the wrong value there. Finally, a third write into a full path must set the overrun bit without the dropped byte ever reaching the line.

// File: rtl/uart9_pkg.sv
package uart9_pkg;
  localparam int TICKS_PER_BIT = 16;
  localparam int TICK_W = $clog2(TICKS_PER_BIT);

  typedef struct packed {
    logic [7:0] data;
    logic       b9;
  } tx_word_t;
endpackage

// File: rtl/uart9_baud.sv
module uart9_baud #(
  parameter int DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       mode_i,
  input  logic             rate_dbl_i,
  input  logic             src_sel_i,
  input  logic             timer_tick_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic             half_clk_q, half_tmr_q;
  logic [DIV_W-1:0] div_cnt_q;
  logic             div_tick;

  assign div_tick = (div_cnt_q >= div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      half_clk_q <= 1'b0;
      half_tmr_q <= 1'b0;
      div_cnt_q  <= '0;
    end else begin
      half_clk_q <= ~half_clk_q;
      if (timer_tick_i) half_tmr_q <= ~half_tmr_q;
      div_cnt_q <= div_tick ? '0 : div_cnt_q + 1'b1;
    end
  end

  always_comb begin
    if (mode_i == 2'd2)  tick_o = rate_dbl_i | half_clk_q;
    else if (src_sel_i)  tick_o = div_tick;
    else                 tick_o = timer_tick_i & (rate_dbl_i | half_tmr_q);
  end

  // R4: at half rate no two fixed-rate ticks in a row
  a_r4_half_rate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && mode_i == 2'd2 && !rate_dbl_i) |=> !(tick_o && mode_i == 2'd2 && !rate_dbl_i));
endmodule

// File: rtl/uart9_hold.sv
module uart9_hold
  import uart9_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     wr_i,
  input  tx_word_t wr_word_i,
  input  logic     dbuf_en_i,
  input  logic     busy_i,
  input  logic     take_i,
  output logic     valid_o,
  output tx_word_t word_o,
  output logic     overrun_o
);
  logic     valid_q, ovr_q, accept;
  tx_word_t word_q;

  // buffered: slot free or freeing now; unbuffered: whole path idle
  assign accept = wr_i && (dbuf_en_i ? (!valid_q || take_i) : (!valid_q && !busy_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      word_q  <= '0;
      ovr_q   <= 1'b0;
    end else begin
      if (accept) begin
        valid_q <= 1'b1;
        word_q  <= wr_word_i;
      end else if (take_i) begin
        valid_q <= 1'b0;
      end
      if (wr_i && !accept) ovr_q <= 1'b1;
    end
  end

  assign valid_o   = valid_q;
  assign word_o    = word_q;
  assign overrun_o = ovr_q;

  // R11: a dropped write leaves the held word untouched
  a_r11_drop_keeps_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !accept) |=> (word_q == $past(word_q)));
endmodule

// File: rtl/uart9_shift.sv
module uart9_shift
  import uart9_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     tick_i,
  input  logic     nine_i,
  input  logic     dbuf_en_i,
  input  logic     bit9_live_i,
  input  logic     hold_valid_i,
  input  tx_word_t hold_word_i,
  output logic     take_o,
  output logic     busy_o,
  output logic     frame_done_o,
  output logic     txd_o
);
  logic              busy_q, txd_q, bit_end, frame_end, nxt_bit;
  logic [TICK_W-1:0] tick_cnt_q;
  logic [3:0]        bit_idx_q, last_idx;
  tx_word_t          sh_q;

  assign last_idx  = nine_i ? 4'd10 : 4'd9;
  assign bit_end   = busy_q && tick_i && (tick_cnt_q == TICK_W'(TICKS_PER_BIT - 1));
  assign frame_end = bit_end && (bit_idx_q == last_idx);
  assign take_o    = hold_valid_i && (!busy_q || frame_end);

  always_comb begin
    if (bit_idx_q <= 4'd7)            nxt_bit = sh_q.data[bit_idx_q[2:0]];
    else if (bit_idx_q == 4'd8 && nine_i) nxt_bit = dbuf_en_i ? sh_q.b9 : bit9_live_i;
    else                              nxt_bit = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q     <= 1'b0;
      txd_q      <= 1'b1;
      tick_cnt_q <= '0;
      bit_idx_q  <= '0;
      sh_q       <= '0;
    end else if (take_o) begin
      sh_q       <= hold_word_i;
      busy_q     <= 1'b1;
      txd_q      <= 1'b0;
      tick_cnt_q <= '0;
      bit_idx_q  <= '0;
    end else if (frame_end) begin
      busy_q     <= 1'b0;
      txd_q      <= 1'b1;
      tick_cnt_q <= '0;
      bit_idx_q  <= '0;
    end else if (busy_q && tick_i) begin
      tick_cnt_q <= tick_cnt_q + 1'b1;
      if (bit_end) begin
        bit_idx_q <= bit_idx_q + 1'b1;
        txd_q     <= nxt_bit;
      end
    end
  end

  assign busy_o       = busy_q;
  assign frame_done_o = frame_end;
  assign txd_o        = txd_q;

  // R2: every load opens with a low start bit
  a_r2_start_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |=> (!txd_o && busy_o));
  // R9: a frame only ends out of a high stop bit
  a_r9_stop_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_end |-> txd_q);
endmodule

// File: rtl/uart9_tx.sv
module uart9_tx
  import uart9_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_i,
  input  logic [7:0]  wr_data_i,
  input  logic        bit9_i,
  input  logic [1:0]  mode_i,
  input  logic        dbuf_en_i,
  input  logic        rate_dbl_i,
  input  logic        src_sel_i,
  input  logic        timer_tick_i,
  input  logic [15:0] div_i,
  input  logic        irq_clr_i,
  output logic        txd_o,
  output logic        tx_irq_o,
  output logic        overrun_o
);
  logic     tick, take, busy, frame_done, hold_valid, irq_q;
  tx_word_t wr_word, hold_word;

  assign wr_word = '{data: wr_data_i, b9: bit9_i};

  uart9_baud #(.DIV_W(16)) u_baud (
    .clk_i, .rst_ni, .mode_i, .rate_dbl_i, .src_sel_i, .timer_tick_i, .div_i,
    .tick_o(tick)
  );

  uart9_hold u_hold (
    .clk_i, .rst_ni, .wr_i, .wr_word_i(wr_word), .dbuf_en_i,
    .busy_i(busy), .take_i(take),
    .valid_o(hold_valid), .word_o(hold_word), .overrun_o
  );

  uart9_shift u_shift (
    .clk_i, .rst_ni, .tick_i(tick), .nine_i(mode_i[1]), .dbuf_en_i,
    .bit9_live_i(bit9_i), .hold_valid_i(hold_valid), .hold_word_i(hold_word),
    .take_o(take), .busy_o(busy), .frame_done_o(frame_done), .txd_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                               irq_q <= 1'b0;
    else if (dbuf_en_i ? take : frame_done)    irq_q <= 1'b1;
    else if (irq_clr_i)                        irq_q <= 1'b0;
  end
  assign tx_irq_o = irq_q;

  a_r1_idle_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> txd_o);
  a_r7_irq_buffer_free: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dbuf_en_i && take) |=> tx_irq_o);
  a_r10_irq_frame_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dbuf_en_i && frame_done) |=> tx_irq_o);
  a_r11_overrun_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_o |=> overrun_o);
endmodule

// File: tb/uart9_tx_tb.sv
module uart9_tx_tb;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [1:0]  mode;
    logic        dbl;
    logic        src;
    logic [15:0] div;
    logic [7:0]  tper;
    logic [7:0]  data;
    logic        b9;
  } vec_t;

  localparam int NVEC = 7;
  localparam vec_t VECS [NVEC] = '{
    '{2'd1, 1'b1, 1'b1, 16'd2, 8'd1, 8'hA5, 1'b0},
    '{2'd2, 1'b1, 1'b0, 16'd0, 8'd1, 8'h3C, 1'b1},
    '{2'd2, 1'b0, 1'b0, 16'd0, 8'd1, 8'h81, 1'b0},
    '{2'd3, 1'b1, 1'b1, 16'd0, 8'd1, 8'h5A, 1'b1},
    '{2'd3, 1'b1, 1'b0, 16'd0, 8'd3, 8'hF0, 1'b0},
    '{2'd1, 1'b0, 1'b0, 16'd0, 8'd2, 8'h0F, 1'b1},
    '{2'd0, 1'b1, 1'b1, 16'd1, 8'd1, 8'hC3, 1'b1}
  };

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        wr = 1'b0, bit9 = 1'b0, dbuf = 1'b0, dbl = 1'b0, src = 1'b0;
  logic        tmr_tick = 1'b0, clr = 1'b0;
  logic [7:0]  wdata = '0;
  logic [1:0]  mode = 2'd1;
  logic [15:0] div = '0;
  logic        txd, irq, ovr, mid_irq = 1'b0;
  logic [31:0] got;
  int          tper = 1, tmr_cnt = 0, errors = 0, checks = 0;

  uart9_tx u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .wr_data_i(wdata), .bit9_i(bit9),
    .mode_i(mode), .dbuf_en_i(dbuf), .rate_dbl_i(dbl), .src_sel_i(src),
    .timer_tick_i(tmr_tick), .div_i(div), .irq_clr_i(clr),
    .txd_o(txd), .tx_irq_o(irq), .overrun_o(ovr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial forever begin
    @(negedge clk);
    if (tmr_cnt >= tper - 1) begin tmr_cnt = 0; tmr_tick = 1'b1; end
    else begin tmr_cnt++; tmr_tick = 1'b0; end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_frame(logic [1:0] m, logic [7:0] d, logic b9);
    logic [31:0] f = '1;
    f[0] = 1'b0;
    f[8:1] = d;
    if (m[1]) f[9] = b9;
    return f;
  endfunction

  function automatic int bit_cycles(vec_t v);
    if (v.mode == 2'd2) return v.dbl ? 16 : 32;
    if (v.src)          return 16 * (int'(v.div) + 1);
    return (v.dbl ? 16 : 32) * int'(v.tper);
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic pulse_wr(input logic [7:0] d);
    wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  // wait for start, sample nb bit centres; at bit act_at: raise bit9, note irq, attempt a write
  task automatic capture(input int nb, input int p, input int act_at);
    int tmo;
    int skip;
    tmo = 0; skip = 0; got = '0;
    while (txd !== 1'b0 && tmo < 5000) begin @(negedge clk); tmo++; end
    if (tmo >= 5000) chk("R2 start bit seen", 32'd0, 32'd1);
    for (int k = 0; k < nb; k++) begin
      repeat (((k == 0) ? p/2 : p) - skip) @(negedge clk);
      skip = 0;
      got[k] = txd;
      if (k == act_at) begin
        bit9 = 1'b1; mid_irq = irq;
        pulse_wr(8'hEE);
        skip = 1;
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    do_reset();
    chk("R1 txd idle", 32'(txd), 32'd1);
    chk("R1 irq clear", 32'(irq), 32'd0);
    chk("R1 overrun clear", 32'(ovr), 32'd0);

    // table: unbuffered frames over all rate sources
    for (int i = 0; i < NVEC; i++) begin
      int nb;
      logic [31:0] mask;
      string tag;
      mode = VECS[i].mode; dbl = VECS[i].dbl; src = VECS[i].src;
      div = VECS[i].div; tper = int'(VECS[i].tper); bit9 = VECS[i].b9; dbuf = 1'b0;
      nb = VECS[i].mode[1] ? 12 : 11;
      mask = (32'd1 << nb) - 1;
      tag = $sformatf("%s/%s vec %0d", VECS[i].mode[1] ? "R3" : "R2",
                      (VECS[i].mode == 2'd2) ? "R4" : (VECS[i].src ? "R5" : "R6"), i);
      @(negedge clk);
      pulse_wr(VECS[i].data);
      capture(nb, bit_cycles(VECS[i]), -1);
      chk(tag, got & mask, exp_frame(VECS[i].mode, VECS[i].data, VECS[i].b9) & mask);
      chk("R10 irq after stop", 32'(irq), 32'd1);
      clr = 1'b1; @(negedge clk); clr = 1'b0;
      chk("R12 irq cleared", 32'(irq), 32'd0);
    end

    // unbuffered: live ninth bit, flag only at frame end, write while busy dropped
    do_reset();
    mode = 2'd2; dbl = 1'b1; dbuf = 1'b0; bit9 = 1'b0;
    pulse_wr(8'h00);
    capture(12, 16, 4);
    chk("R10 ninth bit sampled live", got & 32'hFFF, exp_frame(2'd2, 8'h00, 1'b1) & 32'hFFF);
    chk("R10 no irq mid-frame", 32'(mid_irq), 32'd0);
    chk("R10 irq at frame end", 32'(irq), 32'd1);
    chk("R11 overrun on busy write", 32'(ovr), 32'd1);

    // buffered: A, then B during A, then C dropped
    do_reset();
    mode = 2'd3; src = 1'b1; div = 16'd0; dbuf = 1'b1; bit9 = 1'b1; clr = 1'b0;
    pulse_wr(8'h96);                         // t=-1 -> now at neg1
    @(negedge clk);                          // neg2, t=0: start bit visible
    chk("R7 irq on buffer free", 32'(irq), 32'd1);
    chk("R9 A start", 32'(txd), 32'd0);
    bit9 = 1'b0; clr = 1'b1;
    @(negedge clk);                          // t=1
    clr = 1'b0;
    pulse_wr(8'h4B);                         // B with bit9=0, now t=2
    bit9 = 1'b1;
    pulse_wr(8'h11);                         // C dropped, now t=3
    chk("R11 overrun on full buffer", 32'(ovr), 32'd1);
    got = '0;
    for (int k = 0; k < 23; k++) begin
      repeat ((k == 0) ? 5 : 16) @(negedge clk);
      got[k] = txd;
      if (k == 5) chk("R7 no irq while buffer full", 32'(irq), 32'd0);
    end
    chk("R8/R9 back-to-back frames",
        got & 32'h7FFFFF,
        {9'd0, 1'b1, exp_frame(2'd3, 8'h4B, 1'b0)[10:0], exp_frame(2'd3, 8'h96, 1'b1)[10:0]});
    chk("R9 next start after one stop", 32'(got[11]), 32'd0);
    chk("R8 latched ninth bit of B", 32'(got[20]), 32'd0);
    chk("R11 dropped byte never sent", 32'(got[22]), 32'd1);
    chk("R7 irq when B taken", 32'(irq), 32'd1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule